// File: doc/BRIEF.md
# Byte Output Port with Vectored Interrupt

This block is a byte-wide output peripheral that sits on a processor's memory bus. Software reaches it through three byte registers that decode relative to a base address: a data register, a status register and an interrupt vector register. Each byte written to the data register is held and presented to a slow downstream device over a valid/ready handshake. The port accepts no new byte until the device has taken the current one.

A status byte combines four flags. Ready shows that the data register is free. Error latches a fault reported by the device. Pending records that a transfer has finished. Enable is the software-controlled interrupt enable. While pending and enable are both set, the port drives its interrupt request. When the processor acknowledges, the port places the programmed vector number on the read data bus. This lets the processor find the service routine without polling.

Top module: `byte_out_port`

## Requirements
- R1: After reset the status byte reads 0x80 (ready only), the vector register reads 0x00, `irq` is 0 and `dev_valid` is 0.
- R2: The data register is at BASE+1, status at BASE+3 and vector at BASE+5. A read of any other address returns 0x00. A write to any other address changes no register and starts no transfer.
- R3: A data write while ready is set raises `dev_valid` at the next clock, with `dev_data` equal to the written byte, and clears status bit 7.
- R4: A data write while a byte is still waiting is ignored. `dev_valid` and `dev_data` hold their values until a clock edge at which `dev_ready` is 1.
- R5: At a clock edge where `dev_valid` and `dev_ready` are both 1, the device takes the byte. `dev_valid` drops and status bit 7 reads 1 from the next cycle.
- R6: Status layout: bit 7 ready (read-only), bit 2 interrupt enable (read/write), bit 1 pending (read-only), bit 0 error. Bits 6..3 read as 0.
- R7: Pending sets when the device takes a byte while enable is 1. It stays clear when enable is 0.
- R8: Pending clears after a status read or a data write. `irq` is 1 exactly while pending and enable are both 1.
- R9: A one-cycle pulse on `dev_err` sets status bit 0. Writing status with bit 0 = 1 clears it. Writing bit 0 = 0 leaves it unchanged.
- R10: While `iack` is 1, `rdata` carries the vector register, whatever `rd_en` and `addr` are. With neither `iack` nor `rd_en`, `rdata` is 0x00.
- R11: A byte written to the vector register reads back unchanged. A status read made during an acknowledge does not clear pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Bus byte address |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data, also the vector during acknowledge |
| irq | output | 1 | Interrupt request to the processor |
| iack | input | 1 | Interrupt acknowledge from the processor |
| dev_valid | output | 1 | Byte offered to the device |
| dev_data | output | 8 | Byte offered to the device |
| dev_ready | input | 1 | Device accepts the offered byte |
| dev_err | input | 1 | Device error pulse |

## Verification
The bench builds the port with AW = 8 and BASE = 0x40. With these values it can read and write every one of the 256 addresses, which covers the decode exhaustively, including addresses on both sides of the mapped block. The bench runs sixteen transfers with device stall lengths of zero to three cycles and alternates the interrupt enable. This covers pending setting and not setting, clearing by a status read and by a data write, and the vector returned on acknowledge.

// File: rtl/byte_out_port.sv
module byte_out_port #(
  parameter int AW = 8,
  parameter logic [AW-1:0] BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq,
  input  logic          iack,
  output logic          dev_valid,
  output logic [7:0]    dev_data,
  input  logic          dev_ready,
  input  logic          dev_err
);

  localparam logic [AW-1:0] A_DATA = BASE + AW'(1);
  localparam logic [AW-1:0] A_STAT = BASE + AW'(3);
  localparam logic [AW-1:0] A_VEC  = BASE + AW'(5);

  logic       en_q, pend_q, err_q;
  logic [7:0] vec_q, stat;

  wire wr_data = wr_en && addr == A_DATA;
  wire wr_stat = wr_en && addr == A_STAT;
  wire wr_vec  = wr_en && addr == A_VEC;
  wire rd_stat = rd_en && !iack && addr == A_STAT;
  wire load    = wr_data && !dev_valid;
  wire accept  = dev_valid && dev_ready;

  assign stat = {!dev_valid, 4'b0000, en_q, pend_q, err_q};
  assign irq  = pend_q && en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_valid <= 1'b0;
      dev_data  <= '0;
      en_q      <= 1'b0;
      pend_q    <= 1'b0;
      err_q     <= 1'b0;
      vec_q     <= '0;
    end else begin
      if (load) begin
        dev_valid <= 1'b1;
        dev_data  <= wdata;
      end else if (accept) begin
        dev_valid <= 1'b0;
      end
      if (wr_stat) en_q <= wdata[2];
      if (dev_err) err_q <= 1'b1;
      else if (wr_stat && wdata[0]) err_q <= 1'b0;
      if (accept && en_q) pend_q <= 1'b1;
      else if (rd_stat || wr_data) pend_q <= 1'b0;
      if (wr_vec) vec_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (iack) rdata = vec_q;
    else if (rd_en) begin
      if (addr == A_DATA) rdata = dev_data;
      else if (addr == A_STAT) rdata = stat;
      else if (addr == A_VEC) rdata = vec_q;
    end
  end

  a_r3_load_offers: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> dev_valid && dev_data == $past(wdata));
  a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid && !dev_ready |=> dev_valid && $stable(dev_data));
  a_r5_accept_frees: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !dev_valid);
  a_r7_done_requests: assert property (@(posedge clk) disable iff (!rst_n)
    accept && en_q && !wr_stat |=> irq);
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && !accept |=> !irq);
  a_r9_err_latch: assert property (@(posedge clk) disable iff (!rst_n)
    dev_err |=> stat[0]);

endmodule

// File: tb/test_byte_out_port.sv
module test_byte_out_port;
  localparam logic [7:0] B = 8'h40;

  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wdata = 0, rdata, dev_data;
  logic wr_en = 0, rd_en = 0, iack = 0, irq, dev_valid, dev_ready = 0, dev_err = 0;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  byte_out_port #(.AW(8), .BASE(B)) i_byte_out_port (
    .clk, .rst_n, .addr, .wr_en, .rd_en, .wdata, .rdata, .irq, .iack,
    .dev_valid, .dev_data, .dev_ready, .dev_err);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1; addr = a; #1 v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic dev_take();
    @(negedge clk); dev_ready = 1;
    @(negedge clk); dev_ready = 0;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    rd(B + 3, v); chk(v == 8'h80, "R1 status", v, 8'h80);
    rd(B + 5, v); chk(v == 8'h00, "R1 vector", v, 0);
    chk(!irq && !dev_valid, "R1 irq/valid", {irq, dev_valid}, 0);
    // R2 read sweep
    for (int a = 0; a < 256; a++) begin
      logic [7:0] e;
      e = (a == B + 3) ? 8'h80 : 8'h00;
      rd(8'(a), v); chk(v == e, "R2 read sweep", v, e);
    end
    // R2 writes to unmapped addresses ignored
    for (int a = 0; a < 256; a++)
      if (a != B + 1 && a != B + 3 && a != B + 5) wr(8'(a), 8'hFF);
    rd(B + 3, v); chk(v == 8'h80, "R2 status after stray writes", v, 8'h80);
    rd(B + 5, v); chk(v == 8'h00, "R2 vector after stray writes", v, 0);
    chk(!dev_valid, "R2 no transfer", dev_valid, 0);
    // R11 vector
    wr(B + 5, 8'hA5);
    rd(B + 5, v); chk(v == 8'hA5, "R11 vector readback", v, 8'hA5);
    // R10 idle bus
    #1 chk(rdata == 0, "R10 idle rdata", rdata, 0);

    for (int i = 0; i < 16; i++) begin
      bit en;
      logic [7:0] b;
      en = (i % 2 == 0);
      b = 8'(i * 37 + 1);
      wr(B + 3, {5'b0, en, 2'b00});
      wr(B + 1, b);
      chk(dev_valid && dev_data == b, "R3 offered byte", dev_data, b);
      rd(B + 3, v); chk(v == {5'b0, en, 2'b00}, "R3/R6 busy status", v, {5'b0, en, 2'b00});
      wr(B + 1, ~b);
      chk(dev_valid && dev_data == b, "R4 write while busy ignored", dev_data, b);
      repeat (i % 4) @(negedge clk);
      chk(dev_valid && dev_data == b, "R4 hold during stall", dev_data, b);
      dev_take();
      chk(!dev_valid, "R5 accepted", dev_valid, 0);
      chk(irq == en, "R7 pending follows enable", irq, en);
      if (en && i % 4 == 0) begin
        @(negedge clk); iack = 1; addr = B + 3; rd_en = 1; #1
        chk(rdata == 8'hA5, "R10 vector on iack", rdata, 8'hA5);
        @(negedge clk); iack = 0; rd_en = 0;
        chk(irq, "R11 iack read keeps pending", irq, 1);
        rd(B + 3, v); chk(v == 8'h86, "R6/R8 pending status", v, 8'h86);
        chk(!irq, "R8 status read clears", irq, 0);
        rd(B + 3, v); chk(v == 8'h84, "R8 status after clear", v, 8'h84);
      end else if (en) begin
        wr(B + 1, b + 1);
        chk(!irq, "R8 data write clears", irq, 0);
        chk(dev_data == b + 1, "R3 second byte", dev_data, b + 1);
        dev_take();
        chk(irq, "R7 second completion", irq, 1);
        rd(B + 3, v); chk(v == 8'h86, "R8 status", v, 8'h86);
      end else begin
        rd(B + 3, v); chk(v == 8'h80, "R7 no pending when disabled", v, 8'h80);
      end
    end

    // R9 error flag
    @(negedge clk); dev_err = 1; @(negedge clk); dev_err = 0;
    rd(B + 3, v); chk(v == 8'h81, "R9 error set", v, 8'h81);
    wr(B + 3, 8'h04);
    rd(B + 3, v); chk(v == 8'h85, "R9 zero write keeps error", v, 8'h85);
    wr(B + 3, 8'h01);
    rd(B + 3, v); chk(v == 8'h80, "R9 one write clears error", v, 8'h80);
    chk(!irq, "R8 irq low when disabled", irq, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule